// File: doc/BRIEF.md
# Pipeline Hazard Resolution Unit

This block holds the hazard logic for a five-stage in-order pipeline. The stages run in this order: fetch, decode with register read, execute, memory and write-back. Every instruction writes its result in the last stage, and an ALU operation simply idles through the memory stage. Each cycle the block looks at the two source registers of the instruction in execute and compares them with the destinations waiting in the memory and write-back stages. From that it drives the bypass select for each ALU operand.

The block also looks at the two sources of the instruction in decode. It compares them with a load currently in execute, and with a multiply whose product is not yet ready. When the decode instruction needs a value that bypassing cannot deliver in time, the block holds the program counter and the fetch/decode register. In the same cycle it zeroes the control of the decode/execute register, which inserts a bubble.

The multiply latency is a parameter. A latency of one makes a multiply behave like any ALU operation. Longer latencies are tracked by a single pending-destination register and a down-counter. When no hazard is present, one instruction enters and one retires every cycle.

Top module: `pipe_hazard_unit`

## Requirements
- R1: When the memory-stage instruction writes a nonzero register equal to an execute-stage source, that operand's select is 2'b10 (memory-stage value).
- R2: When only the write-back-stage instruction writes a nonzero register equal to an execute-stage source, that operand's select is 2'b01 (write-back value).
- R3: When both later stages write the same register that an operand reads, the memory-stage value wins (select 2'b10). Each operand is resolved on its own.
- R4: Register 0 is never forwarded (select 2'b00) and never causes a stall, whatever the stage contents are.
- R5: The select is 2'b00 (register file) when no later stage with write enable set has a matching destination.
- R6: A load in execute that writes a nonzero register read by a used decode source asserts hold_front and bubble_idex in that same cycle. The stall is combinational and lasts one cycle once the bubble reaches execute.
- R7: A decode source whose use flag is low never causes a stall.
- R8: With MUL_LAT > 1, a multiply in execute stalls a directly following consumer of its destination for MUL_LAT-1 cycles. A consumer one instruction further back is stalled for MUL_LAT-2 cycles.
- R9: With MUL_LAT = 1, a multiply causes no stall at all.
- R10: An ALU producer (neither load nor multiply) never causes a stall. Its consumers are served by bypassing alone.
- R11: Reset clears any pending multiply. After reset is released, a decode source that matches the old multiply destination does not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_rs | input | REG_AW | First source register of the decode instruction |
| id_rt | input | REG_AW | Second source register of the decode instruction |
| id_use_rs | input | 1 | Decode instruction really reads id_rs |
| id_use_rt | input | 1 | Decode instruction really reads id_rt |
| ex_rs | input | REG_AW | First source register of the execute instruction |
| ex_rt | input | REG_AW | Second source register of the execute instruction |
| ex_rd | input | REG_AW | Destination register of the execute instruction |
| ex_wen | input | 1 | Execute instruction writes ex_rd (0 for a bubble) |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_is_mul | input | 1 | Execute instruction is a multiply |
| mem_rd | input | REG_AW | Destination register of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes mem_rd |
| wb_rd | input | REG_AW | Destination register of the write-back instruction |
| wb_wen | input | 1 | Write-back instruction writes wb_rd |
| fwd_a | output | 2 | Bypass select, first ALU operand |
| fwd_b | output | 2 | Bypass select, second ALU operand |
| hold_front | output | 1 | Hold the program counter and the fetch/decode register |
| bubble_idex | output | 1 | Zero the control of the decode/execute register |

## Verification
The bench builds two copies of the block with 5-bit register numbers. The first copy uses a four-cycle multiply, which makes the counter variant elaborate. That brings the three-cycle stall for an adjacent consumer and the two-cycle stall for a consumer further back within reach, and it allows a reset in the middle of a count. The second copy uses a one-cycle multiply and gets the same stimulus, so the variant without any multiply interlock is compared against the deep one in the same cycles.

// File: rtl/hazard_pkg.sv
`timescale 1ns/1ps
package hazard_pkg;
   // Operand source selection; the encoding is visible on the ports.
   typedef enum logic [1:0] {
      SRC_REGFILE = 2'b00,
      SRC_WBACK   = 2'b01,
      SRC_MEMST   = 2'b10
   } opnd_src_t;

   localparam int NUM_OPND = 2;
endpackage

// File: rtl/hz_opnd_select.sv
`timescale 1ns/1ps
module hz_opnd_select #(
   parameter int REG_AW = 5
) (
   input  logic [REG_AW-1:0]     src,
   input  logic [REG_AW-1:0]     mem_rd,
   input  logic                  mem_wen,
   input  logic [REG_AW-1:0]     wb_rd,
   input  logic                  wb_wen,
   output hazard_pkg::opnd_src_t sel
);
   import hazard_pkg::*;

   logic src_live;
   logic hit_mem;
   logic hit_wb;

   assign src_live = (src != '0);
   assign hit_mem  = src_live && mem_wen && (mem_rd == src);
   assign hit_wb   = src_live && wb_wen  && (wb_rd  == src);

   // The younger producer (memory stage) takes priority.
   always_comb begin
      if (hit_mem)     sel = SRC_MEMST;
      else if (hit_wb) sel = SRC_WBACK;
      else             sel = SRC_REGFILE;
   end
endmodule

// File: rtl/hz_load_use.sv
`timescale 1ns/1ps
module hz_load_use #(
   parameter int REG_AW = 5
) (
   input  logic [REG_AW-1:0] ex_rd,
   input  logic              ex_wen,
   input  logic              ex_is_load,
   input  logic [REG_AW-1:0] id_rs,
   input  logic [REG_AW-1:0] id_rt,
   input  logic              id_use_rs,
   input  logic              id_use_rt,
   output logic              stall
);
   logic producer;
   logic match_rs;
   logic match_rt;

   assign producer = ex_is_load && ex_wen && (ex_rd != '0);
   assign match_rs = id_use_rs && (id_rs == ex_rd);
   assign match_rt = id_use_rt && (id_rt == ex_rd);
   assign stall    = producer && (match_rs || match_rt);
endmodule

// File: rtl/hz_mul_track.sv
`timescale 1ns/1ps
module hz_mul_track #(
   parameter int REG_AW  = 5,
   parameter int MUL_LAT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] ex_rd,
   input  logic              ex_wen,
   input  logic              ex_is_mul,
   input  logic [REG_AW-1:0] id_rs,
   input  logic [REG_AW-1:0] id_rt,
   input  logic              id_use_rs,
   input  logic              id_use_rt,
   output logic              stall
);
   localparam int CNT_W = (MUL_LAT > 2) ? $clog2(MUL_LAT) : 1;

   generate
      if (MUL_LAT <= 1) begin : g_single
         // Product ready in one cycle: plain bypassing covers it.
         assign stall = 1'b0;
      end else begin : g_multi
         logic issue;
         logic ex_hit;

         assign issue  = ex_is_mul && ex_wen && (ex_rd != '0);
         assign ex_hit = issue &&
                         ((id_use_rs && (id_rs == ex_rd)) ||
                          (id_use_rt && (id_rt == ex_rd)));

         if (MUL_LAT == 2) begin : g_short
            assign stall = ex_hit;
         end else begin : g_deep
            logic [CNT_W-1:0]  remain;
            logic [REG_AW-1:0] pend_rd;
            logic              tail_hit;

            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  remain  <= '0;
                  pend_rd <= '0;
               end else if (issue) begin
                  remain  <= CNT_W'(MUL_LAT - 2);
                  pend_rd <= ex_rd;
               end else if (remain != '0) begin
                  remain  <= remain - 1'b1;
               end
            end

            assign tail_hit = (remain != '0) &&
                              ((id_use_rs && (id_rs == pend_rd)) ||
                               (id_use_rt && (id_rt == pend_rd)));
            assign stall = ex_hit || tail_hit;
         end
      end
   endgenerate
endmodule

// File: rtl/pipe_hazard_unit.sv
`timescale 1ns/1ps
module pipe_hazard_unit #(
   parameter int REG_AW  = 5,
   parameter int MUL_LAT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] id_rs,
   input  logic [REG_AW-1:0] id_rt,
   input  logic              id_use_rs,
   input  logic              id_use_rt,
   input  logic [REG_AW-1:0] ex_rs,
   input  logic [REG_AW-1:0] ex_rt,
   input  logic [REG_AW-1:0] ex_rd,
   input  logic              ex_wen,
   input  logic              ex_is_load,
   input  logic              ex_is_mul,
   input  logic [REG_AW-1:0] mem_rd,
   input  logic              mem_wen,
   input  logic [REG_AW-1:0] wb_rd,
   input  logic              wb_wen,
   output logic [1:0]        fwd_a,
   output logic [1:0]        fwd_b,
   output logic              hold_front,
   output logic              bubble_idex
);
   import hazard_pkg::*;

   generate
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
         $error("pipe_hazard_unit: REG_AW out of range");
      end
      if (MUL_LAT < 1) begin : g_bad_lat
         $error("pipe_hazard_unit: MUL_LAT must be at least 1");
      end
   endgenerate

   logic [REG_AW-1:0] opnd_src [NUM_OPND];
   opnd_src_t         opnd_sel [NUM_OPND];

   assign opnd_src[0] = ex_rs;
   assign opnd_src[1] = ex_rt;

   generate
      for (genvar gi = 0; gi < NUM_OPND; gi++) begin : g_opnd
         hz_opnd_select #(.REG_AW(REG_AW)) u_sel (
            .src     (opnd_src[gi]),
            .mem_rd  (mem_rd),
            .mem_wen (mem_wen),
            .wb_rd   (wb_rd),
            .wb_wen  (wb_wen),
            .sel     (opnd_sel[gi])
         );
      end
   endgenerate

   assign fwd_a = opnd_sel[0];
   assign fwd_b = opnd_sel[1];

   logic load_stall;
   logic mul_stall;

   hz_load_use #(.REG_AW(REG_AW)) u_load (
      .ex_rd      (ex_rd),
      .ex_wen     (ex_wen),
      .ex_is_load (ex_is_load),
      .id_rs      (id_rs),
      .id_rt      (id_rt),
      .id_use_rs  (id_use_rs),
      .id_use_rt  (id_use_rt),
      .stall      (load_stall)
   );

   hz_mul_track #(.REG_AW(REG_AW), .MUL_LAT(MUL_LAT)) u_mul (
      .clk       (clk),
      .rst_n     (rst_n),
      .ex_rd     (ex_rd),
      .ex_wen    (ex_wen),
      .ex_is_mul (ex_is_mul),
      .id_rs     (id_rs),
      .id_rt     (id_rt),
      .id_use_rs (id_use_rs),
      .id_use_rt (id_use_rt),
      .stall     (mul_stall)
   );

   assign hold_front  = load_stall || mul_stall;
   assign bubble_idex = load_stall || mul_stall;
endmodule

// File: rtl/hazard_chk.sv
`timescale 1ns/1ps
module hazard_chk #(
   parameter int REG_AW  = 5,
   parameter int MUL_LAT = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [REG_AW-1:0] id_rs,
   input logic [REG_AW-1:0] id_rt,
   input logic              id_use_rs,
   input logic              id_use_rt,
   input logic [REG_AW-1:0] ex_rs,
   input logic [REG_AW-1:0] ex_rt,
   input logic [REG_AW-1:0] ex_rd,
   input logic              ex_wen,
   input logic              ex_is_load,
   input logic              ex_is_mul,
   input logic [REG_AW-1:0] mem_rd,
   input logic              mem_wen,
   input logic [REG_AW-1:0] wb_rd,
   input logic              wb_wen,
   input logic [1:0]        fwd_a,
   input logic [1:0]        fwd_b,
   input logic              hold_front,
   input logic              bubble_idex
);
   // R1
   memfwd_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wen && mem_rd != '0 && mem_rd == ex_rs) |-> fwd_a == 2'b10);

   // R3
   memfwd_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wen && mem_rd != '0 && mem_rd == ex_rt) |-> fwd_b == 2'b10);

   // R2
   wbfwd_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_wen && wb_rd != '0 && wb_rd == ex_rt && !(mem_wen && mem_rd == ex_rt))
      |-> fwd_b == 2'b01);

   // R4
   zero_src_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_rs == '0) |-> fwd_a == 2'b00);

   // R4
   zero_src_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_rt == '0) |-> fwd_b == 2'b00);

   // R5
   idle_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_wen && !wb_wen) |-> (fwd_a == 2'b00 && fwd_b == 2'b00));

   // R7
   no_src_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((!id_use_rs || id_rs == '0) && (!id_use_rt || id_rt == '0))
      |-> (!hold_front && !bubble_idex));

   // R6
   load_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_is_load && ex_wen && ex_rd != '0 &&
       ((id_use_rs && id_rs == ex_rd) || (id_use_rt && id_rt == ex_rd)))
      |-> (hold_front && bubble_idex));

   generate
      if (MUL_LAT > 1) begin : g_mul_head
         // R8
         mul_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ex_is_mul && ex_wen && ex_rd != '0 && id_use_rs && id_rs == ex_rd)
            |-> hold_front);
      end
      if (MUL_LAT > 2) begin : g_mul_tail
         // R8
         mul_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(ex_is_mul && ex_wen && ex_rd != '0) &&
             id_use_rs && id_rs == $past(ex_rd))
            |-> hold_front);
      end
   endgenerate
endmodule

bind pipe_hazard_unit hazard_chk #(.REG_AW(REG_AW), .MUL_LAT(MUL_LAT)) u_chk (
   .clk(clk), .rst_n(rst_n), .id_rs(id_rs), .id_rt(id_rt),
   .id_use_rs(id_use_rs), .id_use_rt(id_use_rt), .ex_rs(ex_rs), .ex_rt(ex_rt),
   .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_is_load(ex_is_load), .ex_is_mul(ex_is_mul),
   .mem_rd(mem_rd), .mem_wen(mem_wen), .wb_rd(wb_rd), .wb_wen(wb_wen),
   .fwd_a(fwd_a), .fwd_b(fwd_b), .hold_front(hold_front), .bubble_idex(bubble_idex)
);

// File: tb/pipe_hazard_unit_tb.sv
`timescale 1ns/1ps
module pipe_hazard_unit_tb;
   localparam int AW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [AW-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
   logic id_use_rs, id_use_rt, ex_wen, ex_is_load, ex_is_mul, mem_wen, wb_wen;
   logic [1:0] fwd_a, fwd_b, fwd_a1, fwd_b1;
   logic hold, bubble, hold1, bubble1;

   pipe_hazard_unit #(.REG_AW(AW), .MUL_LAT(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .id_rs(id_rs), .id_rt(id_rt),
      .id_use_rs(id_use_rs), .id_use_rt(id_use_rt), .ex_rs(ex_rs), .ex_rt(ex_rt),
      .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_is_load(ex_is_load), .ex_is_mul(ex_is_mul),
      .mem_rd(mem_rd), .mem_wen(mem_wen), .wb_rd(wb_rd), .wb_wen(wb_wen),
      .fwd_a(fwd_a), .fwd_b(fwd_b), .hold_front(hold), .bubble_idex(bubble));

   pipe_hazard_unit #(.REG_AW(AW), .MUL_LAT(1)) u_dut_l1 (
      .clk(clk), .rst_n(rst_n), .id_rs(id_rs), .id_rt(id_rt),
      .id_use_rs(id_use_rs), .id_use_rt(id_use_rt), .ex_rs(ex_rs), .ex_rt(ex_rt),
      .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_is_load(ex_is_load), .ex_is_mul(ex_is_mul),
      .mem_rd(mem_rd), .mem_wen(mem_wen), .wb_rd(wb_rd), .wb_wen(wb_wen),
      .fwd_a(fwd_a1), .fwd_b(fwd_b1), .hold_front(hold1), .bubble_idex(bubble1));

   // flg = {mem_wen, wb_wen, ex_wen, ex_is_load, id_use_rs, id_use_rt}
   typedef struct packed {
      logic [4:0] ers, ert, mrd, wrd, irs, irt, xrd;
      logic [5:0] flg;
      logic [1:0] fa, fb;
      logic       st;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t TBL [NV] = '{
      '{5'd3, 5'd0, 5'd3, 5'd0, 5'd0, 5'd0, 5'd0, 6'b100000, 2'b10, 2'b00, 1'b0},   // R1
      '{5'd4, 5'd4, 5'd0, 5'd4, 5'd0, 5'd0, 5'd0, 6'b010000, 2'b01, 2'b01, 1'b0},   // R2
      '{5'd7, 5'd7, 5'd7, 5'd7, 5'd0, 5'd0, 5'd0, 6'b110000, 2'b10, 2'b10, 1'b0},   // R3
      '{5'd7, 5'd9, 5'd7, 5'd9, 5'd0, 5'd0, 5'd0, 6'b110000, 2'b10, 2'b01, 1'b0},   // R3
      '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 6'b110000, 2'b00, 2'b00, 1'b0},   // R4
      '{5'd5, 5'd6, 5'd5, 5'd6, 5'd0, 5'd0, 5'd0, 6'b000000, 2'b00, 2'b00, 1'b0},   // R5
      '{5'd5, 5'd6, 5'd8, 5'd9, 5'd0, 5'd0, 5'd0, 6'b110000, 2'b00, 2'b00, 1'b0},   // R5
      '{5'd0, 5'd0, 5'd0, 5'd0, 5'd10, 5'd0, 5'd10, 6'b001110, 2'b00, 2'b00, 1'b1}, // R6
      '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd11, 5'd11, 6'b001101, 2'b00, 2'b00, 1'b1}, // R6
      '{5'd0, 5'd0, 5'd0, 5'd0, 5'd12, 5'd12, 5'd12, 6'b001100, 2'b00, 2'b00, 1'b0},// R7
      '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 6'b001110, 2'b00, 2'b00, 1'b0},   // R4
      '{5'd0, 5'd0, 5'd0, 5'd0, 5'd13, 5'd0, 5'd13, 6'b001010, 2'b00, 2'b00, 1'b0}, // R10
      '{5'd0, 5'd0, 5'd0, 5'd0, 5'd14, 5'd0, 5'd14, 6'b000110, 2'b00, 2'b00, 1'b0}  // R6
   };

   int checks = 0;
   int errors = 0;
   logic done = 1'b0;

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_inputs();
      {id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd} = '0;
      {id_use_rs, id_use_rt, ex_wen, ex_is_load, ex_is_mul, mem_wen, wb_wen} = '0;
   endtask

   // Move to mid-cycle, drive, settle.
   task automatic step();
      @(negedge clk);
   endtask

   task automatic drive_ex_mul(input logic [AW-1:0] rd);
      ex_is_mul = 1'b1; ex_wen = 1'b1; ex_is_load = 1'b0; ex_rd = rd;
   endtask

   task automatic drive_ex_bubble();
      ex_is_mul = 1'b0; ex_wen = 1'b0; ex_is_load = 1'b0; ex_rd = '0;
   endtask

   initial begin
      clear_inputs();
      repeat (3) @(posedge clk);
      #1;
      // R11: quiet outputs while in reset
      check("R11 reset hold", {7'd0, hold}, 8'd0);
      check("R11 reset fwd", {4'd0, fwd_a, fwd_b}, 8'd0);
      step();
      rst_n = 1'b1;

      // Table walk: combinational forwarding and load-use cases.
      for (int i = 0; i < NV; i++) begin
         step();
         ex_rs = TBL[i].ers; ex_rt = TBL[i].ert;
         mem_rd = TBL[i].mrd; wb_rd = TBL[i].wrd;
         id_rs = TBL[i].irs; id_rt = TBL[i].irt; ex_rd = TBL[i].xrd;
         {mem_wen, wb_wen, ex_wen, ex_is_load, id_use_rs, id_use_rt} = TBL[i].flg;
         ex_is_mul = 1'b0;
         #1;
         check($sformatf("R1-5 vec%0d fwd_a", i), {6'd0, fwd_a}, {6'd0, TBL[i].fa});
         check($sformatf("R1-5 vec%0d fwd_b", i), {6'd0, fwd_b}, {6'd0, TBL[i].fb});
         check($sformatf("R6 R7 R10 vec%0d hold", i), {7'd0, hold}, {7'd0, TBL[i].st});
         check($sformatf("R6 vec%0d bubble", i), {7'd0, bubble}, {7'd0, TBL[i].st});
      end

      // R6: load stall ends once the bubble occupies execute.
      step(); clear_inputs();
      ex_is_load = 1'b1; ex_wen = 1'b1; ex_rd = 5'd15; id_rs = 5'd15; id_use_rs = 1'b1;
      #1 check("R6 load stall", {7'd0, hold}, 8'd1);
      step(); drive_ex_bubble();
      #1 check("R6 one cycle only", {7'd0, hold}, 8'd0);

      // R8 / R9: adjacent consumer of a 4-cycle multiply.
      step(); clear_inputs();
      drive_ex_mul(5'd20); id_rs = 5'd20; id_use_rs = 1'b1;
      #1 check("R8 adj c0", {7'd0, hold}, 8'd1);
      check("R9 lat1 no stall", {7'd0, hold1}, 8'd0);
      step(); drive_ex_bubble();
      #1 check("R8 adj c1", {7'd0, hold}, 8'd1);
      check("R9 lat1 no tail", {7'd0, hold1}, 8'd0);
      step();
      #1 check("R8 adj c2", {7'd0, hold}, 8'd1);
      step();
      #1 check("R8 adj released", {7'd0, hold}, 8'd0);

      // R8: consumer one instruction further back.
      step(); clear_inputs();
      drive_ex_mul(5'd21); id_rs = 5'd1; id_use_rs = 1'b0;
      #1 check("R8 far c0", {7'd0, hold}, 8'd0);
      step();
      ex_is_mul = 1'b0; ex_wen = 1'b1; ex_rd = 5'd2; id_rs = 5'd21; id_use_rs = 1'b1;
      #1 check("R8 far c1", {7'd0, hold}, 8'd1);
      step(); drive_ex_bubble();
      #1 check("R8 far c2", {7'd0, hold}, 8'd1);
      step();
      #1 check("R8 far released", {7'd0, hold}, 8'd0);

      // R11: reset in the middle of a multiply count.
      step(); clear_inputs();
      drive_ex_mul(5'd22);
      step(); drive_ex_bubble(); rst_n = 1'b0;
      step(); rst_n = 1'b1; id_rs = 5'd22; id_use_rs = 1'b1;
      #1 check("R11 pending cleared", {7'd0, hold}, 8'd0);

      // R4: multiply to register 0 never stalls.
      step(); clear_inputs();
      drive_ex_mul(5'd0); id_rs = 5'd0; id_use_rs = 1'b1;
      #1 check("R4 mul r0", {7'd0, hold}, 8'd0);
      step(); clear_inputs();
      #1 check("R4 mul r0 tail", {7'd0, hold}, 8'd0);

      step();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule